// File: doc/BRIEF.md
# LED Driver Fault Readout Sequencer

This block runs the fault-status readout on a serial LED driver that shares one error bit per output channel. On a trigger from a periodic timer elsewhere on the chip, it plays a configurable latch/enable pattern over five serial clocks to put the driver into its special mode. It then starts the detection phase. In that phase the output-enable line is held low while the serial clock keeps toggling. The phase lasts until both a minimum number of system cycles and a minimum number of serial clock edges have passed.

The readout phase starts when the enable line goes back high. The block then clocks in sixteen bits from the driver's serial output, sampling each one while the serial clock is low, just before the rising edge. It plays a second pattern that returns the driver to normal mode. Finally it presents the captured vector and a one-cycle completion pulse. The detection phase has no upper bound, so it can be stretched freely. A trigger that arrives while a cycle is running is dropped.

Top module: `ledfault_seq`

## Requirements
- R1: After reset, `drv_clk` is 0, `drv_le` is 0, `drv_oe` is 1, `drv_sdi` is 0, `fault` is 0, and `done` and `busy` are 0.
- R2: A `trig` seen high in idle raises `busy` from the next cycle. The block then starts the mode-entry pattern. Each serial bit spans two system cycles, first with `drv_clk` low and then with it high. At the k-th rising edge of `drv_clk` (k = 0..4), `drv_le` equals bit k of `ENTER_LE` (default 5'b01000) and `drv_oe` equals bit k of `ENTER_OE` (default 5'b11101).
- R3: After mode entry, `drv_oe` stays low without a break for at least `MIN_LOW_CYC` system cycles (default 100, which is 2 µs at 50 MHz).
- R4: While `drv_oe` is low in the detection phase, `drv_clk` rises at least `MIN_EDGES` times (default 3).
- R5: The readout phase begins when `drv_oe` rises and contains exactly 16 rising edges of `drv_clk`, with `drv_oe` = 1 and `drv_le` = 0 at each of them. `drv_sdi` is 0 for the whole cycle.
- R6: `sdo` is sampled in the system cycle in which `drv_clk` is low just before each readout rising edge. The first bit sampled lands in `fault[15]` and the last in `fault[0]`.
- R7: After readout, five further rising edges carry the mode-exit pattern. At exit edge k, `drv_le` equals bit k of `EXIT_LE` (default 0) and `drv_oe` equals bit k of `EXIT_OE` (default 5'b11101).
- R8: `done` is high for exactly one cycle per sequence. `fault` shows the new vector in that same cycle and keeps it until the next `done`.
- R9: A `trig` that arrives while `busy` is high, including the cycle in which `done` is high, is ignored. After `done`, the block returns to idle with `drv_oe` = 1 and `drv_clk` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Start request from the periodic timer |
| sdo | input | 1 | Serial data returned by the LED driver |
| drv_clk | output | 1 | Serial clock to the driver |
| drv_le | output | 1 | Latch line to the driver |
| drv_oe | output | 1 | Output-enable line to the driver (low enables) |
| drv_sdi | output | 1 | Serial data to the driver |
| fault | output | FW | Last captured fault vector, MSB first |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| busy | output | 1 | High while a sequence is in progress |

## Verification
Two functions can fall in the same cycle: the completion pulse and a fresh timer trigger. In the cycle where `done` is high, the bench raises `trig`. It then confirms that the block goes to idle with no second detection cycle. It does this by checking, at the pins, that `busy` is low, `drv_oe` is high and `drv_clk` is quiet, and that the next sequence's edge count is unchanged. A second trigger pulse in the middle of detection is judged the same way. The recorded edge list must still hold exactly one entry, detection, readout and exit sequence, and `done` must pulse once.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_DETECT,
        ST_READ,
        ST_EXIT,
        ST_DONE
    } lfs_state_e;
endpackage

// File: rtl/lfs_pattern.sv
module lfs_pattern #(
    parameter int          LEN      = 5,
    parameter logic [LEN-1:0] ENTER_LE = 5'b01000,
    parameter logic [LEN-1:0] ENTER_OE = 5'b11101,
    parameter logic [LEN-1:0] EXIT_LE  = 5'b00000,
    parameter logic [LEN-1:0] EXIT_OE  = 5'b11101,
    localparam int IW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic          sel_exit,
    input  logic [IW-1:0] idx,
    output logic          le,
    output logic          oe
);
    always_comb begin
        if (sel_exit) begin
            le = EXIT_LE[idx];
            oe = EXIT_OE[idx];
        end else begin
            le = ENTER_LE[idx];
            oe = ENTER_OE[idx];
        end
    end
endmodule

// File: rtl/lfs_lowtimer.sv
module lfs_lowtimer #(
    parameter int MIN_LOW_CYC = 100,
    parameter int MIN_EDGES   = 3,
    localparam int CW = $clog2(MIN_LOW_CYC + 1),
    localparam int EW = $clog2(MIN_EDGES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise,
    output logic met
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [EW-1:0] edges;
    } lt_t;

    lt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.cnt   = '0;
            r_d.edges = '0;
        end else begin
            if (r_q.cnt < CW'(MIN_LOW_CYC)) r_d.cnt = r_q.cnt + 1'b1;
            if (rise && r_q.edges < EW'(MIN_EDGES)) r_d.edges = r_q.edges + 1'b1;
        end
    end

    // cnt holds cycles before the current one, so MIN-1 includes it
    assign met = (r_q.cnt >= CW'(MIN_LOW_CYC - 1)) && (r_q.edges >= EW'(MIN_EDGES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_LOW_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> ($past(r_q.cnt) >= CW'(MIN_LOW_CYC - 1))); // R3
    AST_LOW_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> ($past(r_q.edges) >= EW'(MIN_EDGES))); // R4
endmodule

// File: rtl/lfs_capture.sv
module lfs_capture #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift,
    input  logic          bit_in,
    input  logic          load,
    output logic [FW-1:0] fault
);
    typedef struct packed {
        logic [FW-1:0] sh;
        logic [FW-1:0] fv;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (shift) c_d.sh = {c_q.sh[FW-2:0], bit_in};
        if (load)  c_d.fv = c_q.sh;
    end

    assign fault = c_q.fv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (c_q.sh[0] == $past(bit_in))); // R6
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(fault)); // R8
endmodule

// File: rtl/ledfault_seq.sv
module ledfault_seq
    import lfs_pkg::*;
#(
    parameter int FW          = 16,
    parameter int MIN_LOW_CYC = 100,
    parameter int MIN_EDGES   = 3,
    parameter int LEN         = 5,
    parameter logic [LEN-1:0] ENTER_LE = 5'b01000,
    parameter logic [LEN-1:0] ENTER_OE = 5'b11101,
    parameter logic [LEN-1:0] EXIT_LE  = 5'b00000,
    parameter logic [LEN-1:0] EXIT_OE  = 5'b11101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          sdo,
    output logic          drv_clk,
    output logic          drv_le,
    output logic          drv_oe,
    output logic          drv_sdi,
    output logic [FW-1:0] fault,
    output logic          done,
    output logic          busy
);
    localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam int MX = (LEN > FW) ? LEN : FW;
    localparam int IW = $clog2(MX);

    typedef struct packed {
        lfs_state_e    st;
        logic          ph;
        logic [IW-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;
    logic met, pat_le, pat_oe, shift, load;

    always_comb begin
        s_d   = s_q;
        shift = 1'b0;
        load  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (trig) begin
                    s_d.st  = ST_ENTER;
                    s_d.ph  = 1'b0;
                    s_d.idx = '0;
                end
            end
            ST_ENTER, ST_EXIT: begin
                s_d.ph = ~s_q.ph;
                if (s_q.ph) begin
                    if (s_q.idx == IW'(LEN - 1)) begin
                        s_d.idx = '0;
                        if (s_q.st == ST_ENTER) begin
                            s_d.st = ST_DETECT;
                        end else begin
                            s_d.st = ST_DONE;
                            load   = 1'b1;
                        end
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_DETECT: begin
                s_d.ph = ~s_q.ph;
                if (s_q.ph && met) begin
                    s_d.st  = ST_READ;
                    s_d.ph  = 1'b0;
                    s_d.idx = '0;
                end
            end
            ST_READ: begin
                s_d.ph = ~s_q.ph;
                shift  = ~s_q.ph;
                if (s_q.ph) begin
                    if (s_q.idx == IW'(FW - 1)) begin
                        s_d.st  = ST_EXIT;
                        s_d.idx = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                s_d.st  = ST_IDLE;
                s_d.ph  = 1'b0;
                s_d.idx = '0;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.ph  <= 1'b0;
            s_q.idx <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    lfs_pattern #(
        .LEN(LEN), .ENTER_LE(ENTER_LE), .ENTER_OE(ENTER_OE),
        .EXIT_LE(EXIT_LE), .EXIT_OE(EXIT_OE)
    ) u_pat (
        .sel_exit (s_q.st == ST_EXIT),
        .idx      (s_q.idx[PW-1:0]),
        .le       (pat_le),
        .oe       (pat_oe)
    );

    lfs_lowtimer #(.MIN_LOW_CYC(MIN_LOW_CYC), .MIN_EDGES(MIN_EDGES)) u_low (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.st == ST_DETECT),
        .rise  (~s_q.ph),
        .met   (met)
    );

    lfs_capture #(.FW(FW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (shift),
        .bit_in (sdo),
        .load   (load),
        .fault  (fault)
    );

    always_comb begin
        drv_clk = 1'b0;
        drv_le  = 1'b0;
        drv_oe  = 1'b1;
        unique case (s_q.st)
            ST_ENTER, ST_EXIT: begin
                drv_clk = s_q.ph;
                drv_le  = pat_le;
                drv_oe  = pat_oe;
            end
            ST_DETECT: begin
                drv_clk = s_q.ph;
                drv_oe  = 1'b0;
            end
            ST_READ: drv_clk = s_q.ph;
            default: ;
        endcase
    end

    assign drv_sdi = 1'b0;
    assign done    = (s_q.st == ST_DONE);
    assign busy    = (s_q.st != ST_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy && !done) |=> busy); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && drv_oe && !drv_clk)); // R9
    AST_DETECT_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DETECT) |-> !drv_oe); // R3
    AST_READ_OE: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_READ) && $rose(drv_clk)) |-> (drv_oe && !drv_le)); // R5
    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !busy) |=> (busy && !drv_clk)); // R2
endmodule

// File: tb/sim_ledfault_seq.sv
module sim_ledfault_seq;
    localparam int FW = 16;
    localparam int LEN = 5;
    localparam int MINC = 100;
    localparam logic [4:0] E_LE = 5'b01000, E_OE = 5'b11101;
    localparam logic [4:0] X_LE = 5'b00000, X_OE = 5'b11101;
    localparam int NV = 5;
    localparam logic [15:0] VEC [NV] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001, 16'h1234};

    logic clk = 0, rst_n = 0, trig = 0, sdo;
    logic drv_clk, drv_le, drv_oe, drv_sdi, done, busy;
    logic [FW-1:0] fault;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    ledfault_seq u0 (
        .clk(clk), .rst_n(rst_n), .trig(trig), .sdo(sdo),
        .drv_clk(drv_clk), .drv_le(drv_le), .drv_oe(drv_oe), .drv_sdi(drv_sdi),
        .fault(fault), .done(done), .busy(busy)
    );

    // monitor and driver-side serial model
    logic [15:0] cur_vec = '0;
    logic le_at [128];
    logic oe_at [128];
    int ne = 0, run = 0, maxrun = 0, sdi_hi = 0, dcnt = 0, rd_k = 0;
    logic prev_clk = 0, in_det = 0, mon_clr = 0;

    always @(negedge clk) begin
        if (mon_clr) begin
            ne = 0; run = 0; maxrun = 0; sdi_hi = 0; dcnt = 0; rd_k = 0; in_det = 0;
        end else begin
            if (drv_clk && !prev_clk) begin
                if (ne < 128) begin
                    le_at[ne] = drv_le;
                    oe_at[ne] = drv_oe;
                end
                if (!drv_oe && ne >= LEN) begin
                    in_det = 1; rd_k = 0;
                end else if (drv_oe && in_det) begin
                    rd_k++;
                end
                ne++;
            end
            if (busy && !drv_oe) run++;
            else begin
                if (run > maxrun) maxrun = run;
                run = 0;
            end
            if (drv_sdi) sdi_hi++;
            if (done) dcnt++;
        end
        prev_clk = drv_clk;
        sdo = (rd_k < 16) ? cur_vec[15 - rd_k] : 1'b0;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected <150000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_one(input logic [15:0] v);
        int d, w;
        bit ok;
        cur_vec = v;
        @(negedge clk) mon_clr = 1;
        @(negedge clk) mon_clr = 0;
        trig = 1;
        @(negedge clk) trig = 0;
        chk(busy == 1'b1, "R2 busy after trig", busy, 1);
        repeat (40) @(negedge clk);
        trig = 1;                      // R9: trigger mid-detection
        @(negedge clk) trig = 0;
        w = 0;
        while (!done && w < 2000) begin @(negedge clk); w++; end
        chk(done == 1'b1, "R8 done seen", done, 1);
        chk(fault == v, "R6 fault vector at done", fault, v);
        trig = 1;                      // R9: trigger in the done cycle
        @(negedge clk) trig = 0;
        chk(!done && !busy, "R9 done cycle trigger dropped", {done, busy}, 0);
        repeat (6) @(negedge clk);
        chk(!busy && drv_oe && !drv_clk, "R9 stays idle", {busy, drv_oe, drv_clk}, 2);
        chk(fault == v, "R8 fault held", fault, v);
        chk(dcnt == 1, "R8 single done", dcnt, 1);
        ok = 1;
        for (int k = 0; k < LEN; k++)
            if (le_at[k] != E_LE[k] || oe_at[k] != E_OE[k]) ok = 0;
        chk(ok, "R2 entry pattern", ok, 1);
        d = 0;
        while (LEN + d < ne && !oe_at[LEN + d]) d++;
        chk(d >= 3, "R4 detect edges", d, 3);
        chk(maxrun >= MINC, "R3 oe low cycles", maxrun, MINC);
        ok = 1;
        for (int k = 0; k < 16; k++)
            if (!oe_at[LEN + d + k] || le_at[LEN + d + k]) ok = 0;
        chk(ok, "R5 readout edges", ok, 1);
        chk(ne == 2 * LEN + d + 16, "R5 edge total", ne, 2 * LEN + d + 16);
        chk(sdi_hi == 0, "R5 sdi low", sdi_hi, 0);
        ok = 1;
        for (int k = 0; k < LEN; k++)
            if (le_at[LEN + d + 16 + k] != X_LE[k] || oe_at[LEN + d + 16 + k] != X_OE[k]) ok = 0;
        chk(ok, "R7 exit pattern", ok, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!drv_clk && !drv_le && drv_oe && !drv_sdi && fault == 0 && !done && !busy,
            "R1 reset state", {drv_clk, drv_le, drv_oe, drv_sdi, done, busy}, 6'b001000);
        rst_n = 1;
        repeat (10) @(negedge clk);
        chk(!busy && drv_oe, "R9 idle without trig", busy, 0);
        for (int i = 0; i < NV; i++) run_one(VEC[i]);
        // reset in the middle of a cycle returns to the reset state
        @(negedge clk) trig = 1;
        @(negedge clk) trig = 0;
        repeat (20) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(!busy && drv_oe && fault == 0, "R1 reset mid-cycle", {busy, drv_oe}, 1);
        rst_n = 1;
        run_one(16'h5A0F);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule